// File: doc/BRIEF.md
# Program Counter with Branch and Jump Target Selection

This block holds the program counter of a 32-bit RISC core. On every clock edge it computes the address of the next instruction and loads it. The current instruction word and the two register operand values read for that instruction are the inputs. Instruction fetch, the register file and hazard handling all sit outside the block.

The next address comes from one of five sources:
- the sequential address (PC+4);
- a taken equal or not-equal conditional branch, relative to PC+4;
- an absolute region jump;
- a region jump that also saves a return address;
- a jump to a register value.

A call presents a write strobe and the return address on the same cycle, for the external register file to store in register 31. A register jump to an address that is not word aligned raises a flag, but the address is still loaded unchanged. A taken transfer takes effect on the next edge. There is no delay slot.

Top module: `pc_next_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads `pc` with the parameter `RESET_VEC`, default 0x0040_0000. A reset overrides any instruction present on that edge.
- R2: Any instruction other than the five listed below advances `pc` by 4 at the next edge. This covers every opcode (bits 31:26) except 2, 3, 4 and 5, and opcode 0 with any function field (bits 5:0) except 8.
- R3: Opcode 4 is a branch taken when `rs_val` equals `rt_val`. When taken, the next `pc` is pc + 4 + 4 × offset, where the offset is instruction bits 15:0. When not taken, the next `pc` is pc + 4.
- R4: Opcode 5 is a branch taken when `rs_val` differs from `rt_val`. It uses the same target arithmetic as R3, and pc + 4 when not taken.
- R5: The 16-bit branch offset is sign-extended before it is scaled, so an offset with bit 15 set moves `pc` backwards.
- R6: Opcode 2 loads `pc` with the current pc bits 31:28, followed by instruction bits 25:0, followed by two zero bits.
- R7: Opcode 3 goes to the same target as R6. While it is presented, `link_we` is 1 and `link_data` equals pc + 4. For every other instruction, `link_we` is 0.
- R8: Opcode 0 with function field 8 loads `pc` with `rs_val` exactly.
- R9: `misalign` is 1 only while an R8 instruction is presented with a nonzero `rs_val[1:0]`. In that case `pc` still loads `rs_val` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction at the current `pc` |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Program counter |
| link_we | output | 1 | Return-address write strobe for register 31 |
| link_data | output | 32 | Return address (pc + 4) |
| misalign | output | 1 | Register-jump target not word aligned |

## Verification
`link_we`, `link_data` and `misalign` are combinational results of the instruction currently presented. The bench therefore samples them a short delay after it drives the inputs, with no clock edge in between. The new `pc` is due exactly one rising edge after the instruction is presented. It is sampled at the following falling edge and compared with a model PC held in the bench. That model is advanced by address arithmetic taken from the requirements. The bench sets arbitrary starting PCs, including every upper nibble for the region jumps, through register jumps.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
   typedef enum logic [2:0] {
      NS_SEQ = 3'd0,
      NS_BR  = 3'd1,
      NS_JMP = 3'd2,
      NS_JAL = 3'd3,
      NS_JR  = 3'd4
   } ns_sel_t;

   localparam int INSTR_W = 32;
   localparam int OPC_LSB = 26;
   localparam int FN_W    = 6;
   localparam int IMM_W   = 16;
   localparam int IDX_W   = 26;

   localparam logic [5:0] OPC_SPECIAL = 6'h00;
   localparam logic [5:0] OPC_JMP     = 6'h02;
   localparam logic [5:0] OPC_CALL    = 6'h03;
   localparam logic [5:0] OPC_BREQ    = 6'h04;
   localparam logic [5:0] OPC_BRNE    = 6'h05;
   localparam logic [5:0] FN_REGJMP   = 6'h08;
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
   import pcu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit CMP_TREE = 1'b1
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0]  opa,
   input  logic [DATA_W-1:0]  opb,
   output ns_sel_t            sel
);
   logic [5:0] opc;
   logic [5:0] fn;
   logic       same;

   assign opc = instr[INSTR_W-1:OPC_LSB];
   assign fn  = instr[FN_W-1:0];

   generate
      if (CMP_TREE) begin : g_cmp_xor
         logic [DATA_W-1:0] diff;
         assign diff = opa ^ opb;
         assign same = ~|diff;
      end else begin : g_cmp_eq
         assign same = (opa == opb);
      end
   endgenerate

   always_comb begin
      sel = NS_SEQ;
      unique case (opc)
         OPC_SPECIAL: if (fn == FN_REGJMP) sel = NS_JR;
         OPC_JMP:     sel = NS_JMP;
         OPC_CALL:    sel = NS_JAL;
         OPC_BREQ:    if (same)  sel = NS_BR;
         OPC_BRNE:    if (!same) sel = NS_BR;
         default:     sel = NS_SEQ;
      endcase
   end
endmodule

// File: rtl/pcu_target.sv
module pcu_target
   import pcu_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ADDR_W-1:0]  pc,
   input  logic [INSTR_W-1:0] instr,
   input  logic [ADDR_W-1:0]  rs_val,
   input  ns_sel_t            sel,
   output logic [ADDR_W-1:0]  next_pc,
   output logic [ADDR_W-1:0]  seq_pc
);
   localparam int EXT_W = ADDR_W - IMM_W - 2;

   logic [ADDR_W-1:0] br_disp;
   logic [ADDR_W-1:0] br_pc;
   logic [ADDR_W-1:0] jmp_pc;
   logic [IMM_W-1:0]  imm;

   assign imm     = instr[IMM_W-1:0];
   assign seq_pc  = pc + ADDR_W'(4);
   assign br_disp = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
   assign br_pc   = seq_pc + br_disp;
   assign jmp_pc  = {pc[ADDR_W-1:IDX_W+2], instr[IDX_W-1:0], 2'b00};

   always_comb begin
      unique case (sel)
         NS_BR:          next_pc = br_pc;
         NS_JMP, NS_JAL: next_pc = jmp_pc;
         NS_JR:          next_pc = rs_val;
         default:        next_pc = seq_pc;
      endcase
   end

   assert_branch_aligned_R3 : assert property (@(posedge clk) disable iff (rst)
      (sel == NS_BR && pc[1:0] == 2'b00) |-> next_pc[1:0] == 2'b00);
   assert_region_kept_R6 : assert property (@(posedge clk) disable iff (rst)
      (sel == NS_JMP || sel == NS_JAL) |-> next_pc[ADDR_W-1:28] == pc[ADDR_W-1:28]);
endmodule

// File: rtl/pcu_pcreg.sv
module pcu_pcreg #(
   parameter int              ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] RESET_VEC = ADDR_W'(32'h0040_0000)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] nxt,
   output logic [ADDR_W-1:0] pc
);
   always_ff @(posedge clk) begin
      if (rst) pc <= RESET_VEC;
      else     pc <= nxt;
   end

   assert_reset_vector_R1 : assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> pc == RESET_VEC);
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
   import pcu_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] RESET_VEC = ADDR_W'(32'h0040_0000),
   parameter bit                CMP_TREE  = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] instr,
   input  logic [ADDR_W-1:0]  rs_val,
   input  logic [ADDR_W-1:0]  rt_val,
   output logic [ADDR_W-1:0]  pc,
   output logic               link_we,
   output logic [ADDR_W-1:0]  link_data,
   output logic               misalign
);
   initial begin
      assert (ADDR_W >= IDX_W + 3)
         else $error("pc_next_unit: ADDR_W too small for region jump");
      assert (RESET_VEC[1:0] == 2'b00)
         else $error("pc_next_unit: RESET_VEC not word aligned");
   end

   ns_sel_t           sel;
   logic [ADDR_W-1:0] next_pc;
   logic [ADDR_W-1:0] seq_pc;

   pcu_decode #(.DATA_W(ADDR_W), .CMP_TREE(CMP_TREE)) u_dec (
      .instr (instr),
      .opa   (rs_val),
      .opb   (rt_val),
      .sel   (sel)
   );

   pcu_target #(.ADDR_W(ADDR_W)) u_tgt (
      .clk     (clk),
      .rst     (rst),
      .pc      (pc),
      .instr   (instr),
      .rs_val  (rs_val),
      .sel     (sel),
      .next_pc (next_pc),
      .seq_pc  (seq_pc)
   );

   pcu_pcreg #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pc (
      .clk (clk),
      .rst (rst),
      .nxt (next_pc),
      .pc  (pc)
   );

   assign link_we   = (sel == NS_JAL);
   assign link_data = seq_pc;
   assign misalign  = (sel == NS_JR) && (rs_val[1:0] != 2'b00);

   assert_seq_step_R2 : assert property (@(posedge clk) disable iff (rst)
      (sel == NS_SEQ) |=> pc == $past(pc) + ADDR_W'(4));
   assert_jr_load_R8 : assert property (@(posedge clk) disable iff (rst)
      (sel == NS_JR) |=> pc == $past(rs_val));
   assert_link_value_R7 : assert property (@(posedge clk) disable iff (rst)
      link_we |-> (link_data == pc + ADDR_W'(4)
                   && instr[INSTR_W-1:OPC_LSB] == OPC_CALL));
   assert_misalign_only_jr_R9 : assert property (@(posedge clk) disable iff (rst)
      misalign |-> (instr[INSTR_W-1:OPC_LSB] == OPC_SPECIAL
                    && instr[FN_W-1:0] == FN_REGJMP));
endmodule

// File: tb/pc_next_unit_tb_top.sv
module pc_next_unit_tb_top;
   localparam logic [31:0] RV = 32'h0040_0000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = 32'h0;
   logic [31:0] rs_val = 32'h0;
   logic [31:0] rt_val = 32'h0;
   logic [31:0] pc;
   logic        link_we;
   logic [31:0] link_data;
   logic        misalign;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [31:0] mpc;

   always #10 clk = ~clk;

   pc_next_unit #(.ADDR_W(32), .RESET_VEC(RV)) dut_i (
      .clk(clk), .rst(rst), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
      .pc(pc), .link_we(link_we), .link_data(link_data), .misalign(misalign)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_jr();
      return {6'd0, 5'd9, 15'd0, 6'h08};
   endfunction

   // Presents one instruction at a falling edge, checks the combinational
   // outputs, then checks pc after the next rising edge.
   task automatic step(input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input string req);
      logic [5:0]  op;
      logic [31:0] seq;
      logic [31:0] nxt;
      logic        is_jr;
      op    = ins[31:26];
      seq   = mpc + 32'd4;
      is_jr = (op == 6'd0) && (ins[5:0] == 6'h08);
      case (op)
         6'd2, 6'd3: nxt = {mpc[31:28], ins[25:0], 2'b00};
         6'd4: nxt = (a == b) ? seq + {{14{ins[15]}}, ins[15:0], 2'b00} : seq;
         6'd5: nxt = (a != b) ? seq + {{14{ins[15]}}, ins[15:0], 2'b00} : seq;
         default: nxt = is_jr ? a : seq;
      endcase
      instr = ins; rs_val = a; rt_val = b;
      #2;
      chk("R7 link_we", {31'd0, link_we}, {31'd0, op == 6'd3});
      if (op == 6'd3) chk("R7 link_data", link_data, seq);
      chk("R9 misalign", {31'd0, misalign}, {31'd0, is_jr && (a[1:0] != 2'b00)});
      @(posedge clk);
      @(negedge clk);
      mpc = nxt;
      chk(req, pc, mpc);
   endtask

   task automatic setpc(input logic [31:0] v);
      step(enc_jr(), v, 32'h0, "R8 jr set");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      mpc = RV;
      chk("R1 reset", pc, RV);
      rst = 1'b0;

      // R2: every non-control opcode, then every non-jr function under opcode 0
      for (int o = 0; o < 64; o++) begin
         if (o >= 2 && o <= 5) continue;
         step({o[5:0], 20'h12345, 6'h20}, 32'h1, 32'h1, "R2 opcode seq");
      end
      for (int f = 0; f < 64; f++) begin
         if (f == 8) continue;
         step({6'd0, 20'h0_0a0f, f[5:0]}, 32'h4, 32'h4, "R2 funct seq");
      end

      // R3/R4/R5: branch offsets, taken and not taken
      setpc(32'h8000_0000);
      for (int k = 0; k < 8; k++) begin
         logic [15:0] off;
         case (k)
            0: off = 16'h0000; 1: off = 16'h0001; 2: off = 16'h0040;
            3: off = 16'h7fff; 4: off = 16'hffff; 5: off = 16'h8000;
            6: off = 16'hfff0; default: off = 16'h0123;
         endcase
         step({6'd4, 10'd0, off}, 32'hCAFE_0001, 32'hCAFE_0001, off[15] ? "R5 beq back" : "R3 beq taken");
         step({6'd4, 10'd0, off}, 32'hCAFE_0001, 32'hCAFE_0003, "R3 beq not taken");
         step({6'd5, 10'd0, off}, 32'h0000_0010, 32'h0000_0011, off[15] ? "R5 bne back" : "R4 bne taken");
         step({6'd5, 10'd0, off}, 32'h7777_7777, 32'h7777_7777, "R4 bne not taken");
      end

      // R6/R7: every upper nibble of the current pc
      for (int u = 0; u < 16; u++) begin
         setpc({u[3:0], 28'h000_0100});
         step({6'd2, 26'h2AA_AAAA ^ 26'(u * 97)}, 32'h0, 32'h0, "R6 jump");
         step({6'd3, 26'h155_5555 ^ 26'(u * 31)}, 32'h0, 32'h0, "R7 call");
      end

      // R8/R9: every low two-bit pattern of a register target
      for (int l = 0; l < 4; l++) begin
         step(enc_jr(), 32'h1234_5670 | 32'(l), 32'h0, "R9 jr target kept");
         step(32'h0, 32'h0, 32'h0, "R2 after jr");
      end

      // R1: reset overrides a taken branch presented on the same edge
      instr = {6'd4, 10'd0, 16'h0010}; rs_val = 32'h5; rt_val = 32'h5;
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      rst = 1'b0; mpc = RV;
      chk("R1 reset over branch", pc, RV);
      step(32'h0, 32'h0, 32'h0, "R2 after reset");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule